// File: doc/BRIEF.md
# Triple Half-Bridge Gate Control and Fault Latch

This block turns a committed control word into the six gate enables of three half-bridges, each bridge made of one high-side and one low-side power switch. Every switch has an enable bit and a PWM-select bit. When the select bit is set, the switch follows one shared PWM pin in addition to its enable bit. A software run bit and a filtered undervoltage condition can force every switch off. Per-switch overtemperature flags and filtered overcurrent flags shut individual switches off and hold them off until software sends a status-reset pulse.

Each bridge has an interlock. A bridge that is asked to turn on both sides drives neither. When one side turns off, the other side may turn on only after a programmable number of clock cycles has passed. The block reports its state through registered status bits: one bit per switch, a temperature prewarning bit, a latched overload bit and a latched supply-fail bit. The status bit of a switch shows its gate state, or shows the open-load indication while open-load detection is enabled and that switch is off.

All outputs are registered. An input sampled on a clock edge shows its effect on the outputs directly after that same edge, unless a delay filter or the dead-time counter holds it back.

Top module: `hb_drive_ctrl`

## Requirements
- R1: A switch's gate is on only if its enable bit is high. If its PWM-select bit is also high, the gate is on only while `pwm_in` is high. A change in `pwm_in` reaches the gate after one clock edge.
- R2: While `ctrl_run` is low, all six gates are off after the next edge. When `ctrl_run` returns high, the requested gates come back.
- R3: `uv_raw` must stay high for `UV_DELAY` consecutive edges. Only then are all gates forced off and `st_supply_fail` set. A shorter pulse has no effect. The gates return one edge after `uv_raw` drops. `st_supply_fail` stays high until a `status_clr` pulse.
- R4: An overtemperature flag on a switch turns that gate off in the same edge, clears the switch's status bit and sets `st_overload`. The switch stays off until its flag has dropped and a `status_clr` pulse arrives.
- R5: With `ctrl_oc_shdn` high, an overcurrent flag that is held for `OC_DELAY` consecutive edges shuts the switch off, clears its status bit and sets `st_overload`. A shorter pulse does nothing. `status_clr` clears `st_overload` and re-enables the switch. With `ctrl_oc_shdn` low, overcurrent never sets `st_overload` and never turns a switch off.
- R6: When `ctrl_ol_det_n` is low and a switch is off, its status bit equals that switch's open-load flag. `status_clr` does not change that bit. When `ctrl_ol_det_n` is high, the status bit of an off switch is 0.
- R7: `st_prewarn` equals `prewarn_in` as sampled on the previous edge, with no latching.
- R8: The high and low gates of one bridge are never on together. A bridge that requests both sides drives neither.
- R9: When a side of a bridge turns off, the counter loads `dead_cycles`. The opposite side then turns on no earlier than `dead_cycles`+1 edges later.
- R10: After reset, all outputs are 0. With no fault active and open-load detection off, each status bit equals its gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_hs_on | input | N | High-side enable per bridge |
| ctrl_ls_on | input | N | Low-side enable per bridge |
| ctrl_hs_pwm | input | N | High side also gated by `pwm_in` |
| ctrl_ls_pwm | input | N | Low side also gated by `pwm_in` |
| ctrl_run | input | 1 | 1 = normal operation, 0 = standby (all off) |
| ctrl_oc_shdn | input | 1 | 1 = overcurrent shutdown armed |
| ctrl_ol_det_n | input | 1 | 0 = open-load reporting enabled |
| pwm_in | input | 1 | Shared PWM pin |
| status_clr | input | 1 | Status-reset request pulse |
| dead_cycles | input | DEAD_W | Dead time in clock cycles |
| ot_hs | input | N | Overtemperature flag, high sides |
| ot_ls | input | N | Overtemperature flag, low sides |
| oc_hs | input | N | Raw overcurrent flag, high sides |
| oc_ls | input | N | Raw overcurrent flag, low sides |
| ol_hs | input | N | Open-load current-low flag, high sides |
| ol_ls | input | N | Open-load current-low flag, low sides |
| uv_raw | input | 1 | Raw supply undervoltage flag |
| prewarn_in | input | 1 | Temperature prewarning flag |
| gate_hs | output | N | High-side gate enables |
| gate_ls | output | N | Low-side gate enables |
| st_hs | output | N | High-side status bits |
| st_ls | output | N | Low-side status bits |
| st_prewarn | output | 1 | Temperature prewarning status |
| st_overload | output | 1 | Latched overload status |
| st_supply_fail | output | 1 | Latched supply-fail status |

## Verification
The assertions check on every cycle that the rules hold in any state:
- no bridge drives both sides, and no side takes over from the other on the very next edge;
- no gate is on without its enable bit;
- standby and overtemperature force gates off;
- the prewarning bit tracks its input;
- the supply-fail and overload latches hold without a clear.

The delay lengths need the bench's scenarios, together with its cycle-accurate reference model. These are the behaviours only the scenarios can show:
- that short undervoltage and overcurrent pulses are ignored;
- that an overtemperature switch comes back only after both the flag clears and a clear pulse arrives;
- that open-load bits survive a status reset;
- the exact edge at which the opposite side turns on after the dead time.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Status bit of one switch: a latched fault forces 0, an off switch with
  // open-load reporting enabled shows its open-load flag, otherwise the gate.
  function automatic logic sw_status(input logic latched,
                                     input logic ol_report,
                                     input logic gate_next,
                                     input logic ol_flag);
    if (latched)
      return 1'b0;
    else if (ol_report && !gate_next)
      return ol_flag;
    else
      return gate_next;
  endfunction

  typedef enum logic [1:0] {
    LEG_IDLE = 2'd0,
    LEG_LOW  = 2'd1,
    LEG_HIGH = 2'd2
  } leg_state_e;

endpackage

// File: rtl/hb_delay_filter.sv
module hb_delay_filter #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic det_next
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  // Counts consecutive high samples, saturating at DELAY, cleared on a low.
  always_comb begin
    if (!raw)
      cnt_d = '0;
    else if (cnt_q == CW'(DELAY))
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
  end

  assign det_next = (cnt_d == CW'(DELAY));

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
  parameter int OC_DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ot,
  input  logic oc_raw,
  input  logic oc_arm,
  input  logic clr,
  output logic trip_next,
  output logic off_next
);
  logic oc_det;
  logic off_q;

  hb_delay_filter #(.DELAY(OC_DELAY)) u_oc_filt (
    .clk      (clk),
    .rst      (rst),
    .raw      (oc_raw),
    .det_next (oc_det)
  );

  assign trip_next = oc_arm & oc_det;
  // A live fault dominates the clear request.
  assign off_next  = ot | trip_next | (off_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst)
      off_q <= 1'b0;
    else
      off_q <= off_next;
  end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_hi,
  input  logic              req_lo,
  input  logic [DEAD_W-1:0] dead_cycles,
  input  logic              off_hi,
  input  logic              off_lo,
  input  logic              ol_report,
  input  logic              ol_hi,
  input  logic              ol_lo,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              st_hi,
  output logic              st_lo
);
  leg_state_e        state_q, state_d;
  logic [DEAD_W-1:0] dead_q, dead_d;
  logic              want_hi, want_lo;
  logic              g_hi_d, g_lo_d;

  assign want_hi = req_hi & ~req_lo;
  assign want_lo = req_lo & ~req_hi;

  always_comb begin
    state_d = state_q;
    dead_d  = dead_q;
    case (state_q)
      LEG_HIGH: if (!want_hi) begin
        state_d = LEG_IDLE;
        dead_d  = dead_cycles;
      end
      LEG_LOW: if (!want_lo) begin
        state_d = LEG_IDLE;
        dead_d  = dead_cycles;
      end
      default: begin
        if (dead_q != '0)
          dead_d = dead_q - 1'b1;
        else if (want_hi)
          state_d = LEG_HIGH;
        else if (want_lo)
          state_d = LEG_LOW;
      end
    endcase
  end

  assign g_hi_d = (state_d == LEG_HIGH);
  assign g_lo_d = (state_d == LEG_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LEG_IDLE;
      dead_q  <= '0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      st_hi   <= 1'b0;
      st_lo   <= 1'b0;
    end else begin
      state_q <= state_d;
      dead_q  <= dead_d;
      gate_hi <= g_hi_d;
      gate_lo <= g_lo_d;
      st_hi   <= sw_status(off_hi, ol_report, g_hi_d, ol_hi);
      st_lo   <= sw_status(off_lo, ol_report, g_lo_d, ol_lo);
    end
  end
endmodule

// File: rtl/hb_drive_ctrl.sv
module hb_drive_ctrl #(
  parameter int N        = 3,
  parameter int UV_DELAY = 8,
  parameter int OC_DELAY = 5,
  parameter int DEAD_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      ctrl_hs_on,
  input  logic [N-1:0]      ctrl_ls_on,
  input  logic [N-1:0]      ctrl_hs_pwm,
  input  logic [N-1:0]      ctrl_ls_pwm,
  input  logic              ctrl_run,
  input  logic              ctrl_oc_shdn,
  input  logic              ctrl_ol_det_n,
  input  logic              pwm_in,
  input  logic              status_clr,
  input  logic [DEAD_W-1:0] dead_cycles,
  input  logic [N-1:0]      ot_hs,
  input  logic [N-1:0]      ot_ls,
  input  logic [N-1:0]      oc_hs,
  input  logic [N-1:0]      oc_ls,
  input  logic [N-1:0]      ol_hs,
  input  logic [N-1:0]      ol_ls,
  input  logic              uv_raw,
  input  logic              prewarn_in,
  output logic [N-1:0]      gate_hs,
  output logic [N-1:0]      gate_ls,
  output logic [N-1:0]      st_hs,
  output logic [N-1:0]      st_ls,
  output logic              st_prewarn,
  output logic              st_overload,
  output logic              st_supply_fail
);
  logic         uv_next;
  logic [N-1:0] trip_hs, trip_ls, off_hs, off_ls;
  logic [N-1:0] req_hs, req_ls;
  logic         ol_report;
  logic         ovl_set;

  assign ol_report = ~ctrl_ol_det_n;

  hb_delay_filter #(.DELAY(UV_DELAY)) u_uv_filt (
    .clk      (clk),
    .rst      (rst),
    .raw      (uv_raw),
    .det_next (uv_next)
  );

  for (genvar b = 0; b < N; b++) begin : g_bridge
    hb_fault_latch #(.OC_DELAY(OC_DELAY)) u_flt_hi (
      .clk       (clk),
      .rst       (rst),
      .ot        (ot_hs[b]),
      .oc_raw    (oc_hs[b]),
      .oc_arm    (ctrl_oc_shdn),
      .clr       (status_clr),
      .trip_next (trip_hs[b]),
      .off_next  (off_hs[b])
    );

    hb_fault_latch #(.OC_DELAY(OC_DELAY)) u_flt_lo (
      .clk       (clk),
      .rst       (rst),
      .ot        (ot_ls[b]),
      .oc_raw    (oc_ls[b]),
      .oc_arm    (ctrl_oc_shdn),
      .clr       (status_clr),
      .trip_next (trip_ls[b]),
      .off_next  (off_ls[b])
    );

    assign req_hs[b] = ctrl_hs_on[b] & (~ctrl_hs_pwm[b] | pwm_in)
                       & ctrl_run & ~uv_next & ~off_hs[b];
    assign req_ls[b] = ctrl_ls_on[b] & (~ctrl_ls_pwm[b] | pwm_in)
                       & ctrl_run & ~uv_next & ~off_ls[b];

    hb_leg #(.DEAD_W(DEAD_W)) u_leg (
      .clk         (clk),
      .rst         (rst),
      .req_hi      (req_hs[b]),
      .req_lo      (req_ls[b]),
      .dead_cycles (dead_cycles),
      .off_hi      (off_hs[b]),
      .off_lo      (off_ls[b]),
      .ol_report   (ol_report),
      .ol_hi       (ol_hs[b]),
      .ol_lo       (ol_ls[b]),
      .gate_hi     (gate_hs[b]),
      .gate_lo     (gate_ls[b]),
      .st_hi       (st_hs[b]),
      .st_lo       (st_ls[b])
    );
  end

  assign ovl_set = (|ot_hs) | (|ot_ls) | (|trip_hs) | (|trip_ls);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_prewarn     <= 1'b0;
      st_overload    <= 1'b0;
      st_supply_fail <= 1'b0;
    end else begin
      st_prewarn     <= prewarn_in;
      st_overload    <= ovl_set | (st_overload & ~status_clr);
      st_supply_fail <= uv_next | (st_supply_fail & ~status_clr);
    end
  end
endmodule

// File: rtl/hb_drive_ctrl_chk.sv
module hb_drive_ctrl_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] ctrl_hs_on,
  input logic [N-1:0] ctrl_ls_on,
  input logic         ctrl_run,
  input logic         ctrl_oc_shdn,
  input logic         status_clr,
  input logic [N-1:0] ot_hs,
  input logic [N-1:0] ot_ls,
  input logic         prewarn_in,
  input logic [N-1:0] gate_hs,
  input logic [N-1:0] gate_ls,
  input logic [N-1:0] st_hs,
  input logic [N-1:0] st_ls,
  input logic         st_prewarn,
  input logic         st_overload,
  input logic         st_supply_fail
);
  // R8
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hs & gate_ls) == '0);

  // R9
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate_ls & $past(gate_hs)) == '0) && ((gate_hs & $past(gate_ls)) == '0));

  // R1
  gate_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gate_hs & ~$past(ctrl_hs_on)) == '0) && ((gate_ls & ~$past(ctrl_ls_on)) == '0));

  // R2
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_run |=> (gate_hs | gate_ls) == '0);

  // R3
  supply_fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st_supply_fail && !status_clr |=> st_supply_fail);

  // R4
  overtemp_off_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((gate_hs | st_hs) & $past(ot_hs)) == '0) && (((gate_ls | st_ls) & $past(ot_ls)) == '0));

  // R4
  overload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st_overload && !status_clr |=> st_overload);

  // R5
  oc_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_oc_shdn && ot_hs == '0 && ot_ls == '0 && !st_overload |=> !st_overload);

  // R7
  prewarn_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> st_prewarn == $past(prewarn_in));
endmodule

bind hb_drive_ctrl hb_drive_ctrl_chk #(.N(N)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ctrl_hs_on     (ctrl_hs_on),
  .ctrl_ls_on     (ctrl_ls_on),
  .ctrl_run       (ctrl_run),
  .ctrl_oc_shdn   (ctrl_oc_shdn),
  .status_clr     (status_clr),
  .ot_hs          (ot_hs),
  .ot_ls          (ot_ls),
  .prewarn_in     (prewarn_in),
  .gate_hs        (gate_hs),
  .gate_ls        (gate_ls),
  .st_hs          (st_hs),
  .st_ls          (st_ls),
  .st_prewarn     (st_prewarn),
  .st_overload    (st_overload),
  .st_supply_fail (st_supply_fail)
);

// File: tb/hb_drive_ctrl_test.sv
`timescale 1ns/1ps
module hb_drive_ctrl_test;
  localparam int N   = 3;
  localparam int UVD = 8;
  localparam int OCD = 5;
  localparam int DW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] ctrl_hs_on = '0, ctrl_ls_on = '0, ctrl_hs_pwm = '0, ctrl_ls_pwm = '0;
  logic ctrl_run = 1'b0, ctrl_oc_shdn = 1'b0, ctrl_ol_det_n = 1'b1;
  logic pwm_in = 1'b0, status_clr = 1'b0;
  logic [DW-1:0] dead_cycles = '0;
  logic [N-1:0] ot_hs = '0, ot_ls = '0, oc_hs = '0, oc_ls = '0, ol_hs = '0, ol_ls = '0;
  logic uv_raw = 1'b0, prewarn_in = 1'b0;
  logic [N-1:0] gate_hs, gate_ls, st_hs, st_ls;
  logic st_prewarn, st_overload, st_supply_fail;

  always #2.5 clk = ~clk;

  hb_drive_ctrl #(.N(N), .UV_DELAY(UVD), .OC_DELAY(OCD), .DEAD_W(DW)) uut (
    .clk(clk), .rst(rst),
    .ctrl_hs_on(ctrl_hs_on), .ctrl_ls_on(ctrl_ls_on),
    .ctrl_hs_pwm(ctrl_hs_pwm), .ctrl_ls_pwm(ctrl_ls_pwm),
    .ctrl_run(ctrl_run), .ctrl_oc_shdn(ctrl_oc_shdn), .ctrl_ol_det_n(ctrl_ol_det_n),
    .pwm_in(pwm_in), .status_clr(status_clr), .dead_cycles(dead_cycles),
    .ot_hs(ot_hs), .ot_ls(ot_ls), .oc_hs(oc_hs), .oc_ls(oc_ls),
    .ol_hs(ol_hs), .ol_ls(ol_ls), .uv_raw(uv_raw), .prewarn_in(prewarn_in),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .st_hs(st_hs), .st_ls(st_ls),
    .st_prewarn(st_prewarn), .st_overload(st_overload), .st_supply_fail(st_supply_fail)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit armed  = 1'b0;
  string tag = "R10";

  // Behavioural reference model. Switch s: bridge s/2, s odd = high side.
  int m_uvc;
  int m_occ [2*N];
  bit m_off [2*N];
  bit m_g   [2*N];
  bit m_st  [2*N];
  int m_dead [N];
  bit m_ovl, m_sf, m_pw;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      summary();
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_uvc = 0; m_ovl = 0; m_sf = 0; m_pw = 0;
      for (int s = 0; s < 2*N; s++) begin
        m_occ[s] = 0; m_off[s] = 0; m_g[s] = 0; m_st[s] = 0;
      end
      for (int b = 0; b < N; b++) m_dead[b] = 0;
    end else begin
      bit uv, set_ovl;
      bit req [2*N];
      if (uv_raw) m_uvc = (m_uvc < UVD) ? m_uvc + 1 : UVD;
      else        m_uvc = 0;
      uv = (m_uvc == UVD);
      set_ovl = 0;
      for (int s = 0; s < 2*N; s++) begin
        int b;
        bit hi, ot, oc, en, sel, trip;
        b  = s / 2;
        hi = (s % 2) == 1;
        ot  = hi ? ot_hs[b] : ot_ls[b];
        oc  = hi ? oc_hs[b] : oc_ls[b];
        en  = hi ? ctrl_hs_on[b] : ctrl_ls_on[b];
        sel = hi ? ctrl_hs_pwm[b] : ctrl_ls_pwm[b];
        if (oc) m_occ[s] = (m_occ[s] < OCD) ? m_occ[s] + 1 : OCD;
        else    m_occ[s] = 0;
        trip = ctrl_oc_shdn && (m_occ[s] == OCD);
        m_off[s] = ot || trip || (m_off[s] && !status_clr);
        if (ot || trip) set_ovl = 1;
        req[s] = en && (!sel || pwm_in) && ctrl_run && !uv && !m_off[s];
      end
      for (int b = 0; b < N; b++) begin
        bit wh, wl;
        wh = req[2*b+1] && !req[2*b];
        wl = req[2*b] && !req[2*b+1];
        if (m_g[2*b+1]) begin
          if (!wh) begin m_g[2*b+1] = 0; m_dead[b] = int'(dead_cycles); end
        end else if (m_g[2*b]) begin
          if (!wl) begin m_g[2*b] = 0; m_dead[b] = int'(dead_cycles); end
        end else if (m_dead[b] > 0) begin
          m_dead[b]--;
        end else if (wh) begin
          m_g[2*b+1] = 1;
        end else if (wl) begin
          m_g[2*b] = 1;
        end
      end
      for (int s = 0; s < 2*N; s++) begin
        bit olf;
        olf = (s % 2) ? ol_hs[s/2] : ol_ls[s/2];
        if (m_off[s])                      m_st[s] = 0;
        else if (!ctrl_ol_det_n && !m_g[s]) m_st[s] = olf;
        else                               m_st[s] = m_g[s];
      end
      m_ovl = set_ovl || (m_ovl && !status_clr);
      m_sf  = uv || (m_sf && !status_clr);
      m_pw  = prewarn_in;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      logic [4*N+2:0] exp_v, act_v;
      for (int b = 0; b < N; b++) begin
        exp_v[b]       = m_g[2*b+1];
        exp_v[N+b]     = m_g[2*b];
        exp_v[2*N+b]   = m_st[2*b+1];
        exp_v[3*N+b]   = m_st[2*b];
      end
      exp_v[4*N]   = m_pw;
      exp_v[4*N+1] = m_ovl;
      exp_v[4*N+2] = m_sf;
      act_v = {st_supply_fail, st_overload, st_prewarn, st_ls, st_hs, gate_ls, gate_hs};
      checks++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s model compare: actual %h expected %h", tag, act_v, exp_v);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse_clr();
    status_clr = 1'b1;
    step(1);
    status_clr = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    armed = 1'b1;
    tag = "R10";
    chk("R10", "reset outputs",
        {28'd0, gate_hs, gate_ls, st_hs, st_ls, st_prewarn, st_overload, st_supply_fail}, 32'd0);
    ctrl_run = 1'b1;
    ctrl_oc_shdn = 1'b1;

    // R1: enable and PWM gating
    tag = "R1";
    ctrl_hs_on = 3'b001;
    step(1);
    chk("R1", "hs0 on", gate_hs, 3'b001);
    chk("R10", "status equals gate", st_hs, 3'b001);
    ctrl_hs_pwm = 3'b001;
    pwm_in = 1'b0;
    step(1);
    chk("R1", "pwm low gates off", gate_hs, 3'b000);
    pwm_in = 1'b1;
    step(1);
    chk("R1", "pwm high gates on", gate_hs, 3'b001);
    ctrl_hs_pwm = '0;

    // R8: both sides requested
    tag = "R8";
    ctrl_hs_on[1] = 1'b1;
    ctrl_ls_on[1] = 1'b1;
    step(3);
    chk("R8", "both requested high", gate_hs[1], 1'b0);
    chk("R8", "both requested low", gate_ls[1], 1'b0);
    ctrl_ls_on[1] = 1'b0;
    ctrl_hs_on[1] = 1'b0;
    step(1);

    // R9: dead time between sides
    tag = "R9";
    dead_cycles = 4'd3;
    ctrl_hs_on[2] = 1'b1;
    step(1);
    chk("R9", "hs2 on", gate_hs[2], 1'b1);
    ctrl_hs_on[2] = 1'b0;
    ctrl_ls_on[2] = 1'b1;
    step(4);
    chk("R9", "ls2 held in dead time", gate_ls[2], 1'b0);
    step(1);
    chk("R9", "ls2 on after dead time", gate_ls[2], 1'b1);
    dead_cycles = '0;
    ctrl_ls_on[2] = 1'b0;
    step(2);

    // R2: standby
    tag = "R2";
    ctrl_hs_on = 3'b101;
    step(2);
    chk("R2", "gates before standby", gate_hs, 3'b101);
    ctrl_run = 1'b0;
    step(1);
    chk("R2", "standby gates off", {gate_hs, gate_ls}, 6'd0);
    ctrl_run = 1'b1;
    step(1);
    chk("R2", "gates back after standby", gate_hs, 3'b101);

    // R6: open-load reporting
    tag = "R6";
    ctrl_ol_det_n = 1'b0;
    ol_ls = 3'b010;
    step(1);
    chk("R6", "open-load shown on off switch", st_ls, 3'b010);
    pulse_clr();
    chk("R6", "clear leaves open-load bit", st_ls, 3'b010);
    ctrl_ol_det_n = 1'b1;
    step(1);
    chk("R6", "reporting disabled", st_ls, 3'b000);
    ol_ls = '0;

    // R4: overtemperature
    tag = "R4";
    ot_hs = 3'b001;
    step(1);
    chk("R4", "hs0 shut down", gate_hs, 3'b100);
    chk("R4", "hs0 status cleared", st_hs, 3'b100);
    chk("R4", "overload set", st_overload, 1'b1);
    pulse_clr();
    chk("R4", "clear while hot keeps off", gate_hs[0], 1'b0);
    ot_hs = '0;
    step(2);
    chk("R4", "cool without clear stays off", gate_hs[0], 1'b0);
    chk("R4", "overload held", st_overload, 1'b1);
    pulse_clr();
    chk("R4", "re-enabled after clear", gate_hs[0], 1'b1);
    chk("R4", "overload cleared", st_overload, 1'b0);

    // R5: overcurrent
    tag = "R5";
    oc_hs[2] = 1'b1;
    step(OCD - 1);
    oc_hs[2] = 1'b0;
    step(1);
    chk("R5", "short pulse ignored", gate_hs[2], 1'b1);
    chk("R5", "short pulse no overload", st_overload, 1'b0);
    oc_hs[2] = 1'b1;
    step(OCD);
    chk("R5", "trip after delay", gate_hs[2], 1'b0);
    chk("R5", "overload on trip", st_overload, 1'b1);
    oc_hs[2] = 1'b0;
    step(1);
    chk("R5", "stays off without clear", gate_hs[2], 1'b0);
    pulse_clr();
    chk("R5", "re-enabled by clear", gate_hs[2], 1'b1);
    ctrl_oc_shdn = 1'b0;
    oc_hs[2] = 1'b1;
    step(OCD + 3);
    chk("R5", "disarmed no overload", st_overload, 1'b0);
    chk("R5", "disarmed stays on", gate_hs[2], 1'b1);
    oc_hs[2] = 1'b0;
    ctrl_oc_shdn = 1'b1;

    // R3: undervoltage
    tag = "R3";
    uv_raw = 1'b1;
    step(UVD - 1);
    uv_raw = 1'b0;
    step(1);
    chk("R3", "short dip ignored", st_supply_fail, 1'b0);
    chk("R3", "gates kept", gate_hs, 3'b101);
    uv_raw = 1'b1;
    step(UVD);
    chk("R3", "gates off on undervoltage", gate_hs, 3'b000);
    chk("R3", "supply fail set", st_supply_fail, 1'b1);
    uv_raw = 1'b0;
    step(1);
    chk("R3", "gates back on recovery", gate_hs, 3'b101);
    chk("R3", "supply fail latched", st_supply_fail, 1'b1);
    pulse_clr();
    chk("R3", "supply fail cleared", st_supply_fail, 1'b0);

    // R7: prewarning
    tag = "R7";
    prewarn_in = 1'b1;
    step(1);
    chk("R7", "prewarn set", st_prewarn, 1'b1);
    prewarn_in = 1'b0;
    step(1);
    chk("R7", "prewarn cleared", st_prewarn, 1'b0);

    // Mixed random phase against the model (R1 R8 R9 and fault paths)
    tag = "R1/R8/R9 random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r, q;
      r = $urandom;
      q = $urandom;
      ctrl_hs_on  = r[2:0];
      ctrl_ls_on  = r[5:3];
      ctrl_hs_pwm = r[8:6];
      ctrl_ls_pwm = r[11:9];
      pwm_in      = r[12];
      ctrl_run    = (r[15:13] != 3'd0);
      ctrl_oc_shdn  = r[16];
      ctrl_ol_det_n = r[17];
      ol_hs = r[20:18];
      ol_ls = r[23:21];
      status_clr = (q[3:0] == 4'd0);
      dead_cycles = DW'(q[5:4]);
      ot_hs = (q[11:6] == 6'd0) ? q[14:12] : 3'd0;
      ot_ls = (q[20:15] == 6'd0) ? q[23:21] : 3'd0;
      oc_hs = (q[24]) ? 3'b000 : oc_hs ^ {2'b00, q[25]};
      oc_ls = (q[26]) ? 3'b000 : oc_ls ^ {q[27], 2'b00};
      uv_raw = (q[29:28] == 2'd0) ? ~uv_raw : uv_raw;
      prewarn_in = q[30];
      step(1);
    end
    step(2);
    summary();
  end
endmodule